// File: doc/BRIEF.md
# Pipelined Two-Input Reduction Node

This block is one active node of a binary reduction tree that carries data from the leaves toward a single root. Two child streams enter the node: the children are processing units or lower nodes. Each stream delivers signed words with a coordinate tag. The node pairs one word from each side, combines them, and sends one result word upward. Nodes chain into a complete subtree per board, and board subtrees chain further into a partial tree that ends at the master. Because the node is pipelined, a new pair can be combined while the previous result is still waiting to move up.

A two-bit mode selects the combine operation. Summation adds the two values and wraps on overflow. Minimum search keeps the smaller value together with its tag, so the root receives both the best distance and the location of the element that produced it. Maximum search keeps the larger value. A pass-through mode forwards the left stream unchanged and ignores the right side, which lets the same node route external data down toward a group of processing units. The mode is captured only while the node holds no operand, so a mode change cannot split a pair.

Each side has a one-word capture slot with a valid/ready handshake. The result sits in an output register with its own valid/ready handshake. A side whose slot is occupied and cannot drain drops its ready signal, which stalls its producer.

Top module: `redux_node`

## Requirements
- R1: In mode 2'b00 (sum), the result data is the 32-bit wrapped sum of the left and right values and the result tag is the left tag.
- R2: In mode 2'b01 (minimum), the right value and right tag are forwarded only if the right value is strictly smaller as a signed 32-bit number. Otherwise the left value and left tag are forwarded, including on a tie.
- R3: In mode 2'b10 (maximum), the right value and right tag are forwarded only if the right value is strictly larger as a signed number. Otherwise the left value and left tag are forwarded.
- R4: In mode 2'b11 (pass), each left word is forwarded with its tag unchanged, one result per left word. rightReady stays low and right words are never captured.
- R5: No result is produced until both slots hold a word (only the left slot in pass mode). Words are paired strictly in arrival order per side. While a captured word waits for its partner, its side's ready stays low.
- R6: When the output register is free, a result becomes valid at the clock edge after the edge that captured the second operand. If both operands are presented in the same cycle, this is two edges after they are presented.
- R7: While outValid is high and outReady is low, outData and outTag hold their values. A side whose slot is full cannot accept a new word.
- R8: modeIn is sampled only at edges where both slots are empty. A mode change made while a word waits does not affect the pair that word belongs to.
- R9: After reset, outValid is low, both slots are empty, and leftReady and rightReady are high in sum mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 2 | Combine mode: 00 sum, 01 minimum, 10 maximum, 11 pass left |
| leftValid | input | 1 | Left word offered |
| leftReady | output | 1 | Left slot can take a word this cycle |
| leftData | input | DATA_W | Left value |
| leftTag | input | TAG_W | Left coordinate tag |
| rightValid | input | 1 | Right word offered |
| rightReady | output | 1 | Right slot can take a word this cycle |
| rightData | input | DATA_W | Right value |
| rightTag | input | TAG_W | Right coordinate tag |
| outValid | output | 1 | Result word held |
| outReady | input | 1 | Parent takes the result this cycle |
| outData | output | DATA_W | Result value |
| outTag | output | TAG_W | Tag travelling with the result |

## Verification
A word is captured at the edge where its valid and ready are both high. The combined result becomes visible one edge later, and only if the output register is free. A pair presented together therefore shows its result after the second edge. The latency check samples at the falling edge after the capture edge, where it expects no output yet. It samples again one edge later, where it expects the result. All other results go through an in-order queue of expected words. The queue is compared on falling edges in which outValid and outReady are both high, so a throttled parent or a waiting partner shifts results in time without breaking the comparison. Stall checks sample ready and the held output on falling edges between parent cycles.

// File: rtl/redux_pkg.sv
package redux_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MIN  = 2'd1,
    OP_MAX  = 2'd2,
    OP_PASS = 2'd3
  } redOp_e;

  localparam int SIDES  = 2;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [SIDES-1:0] load;
    logic             fire;
    redOp_e           op;
  } redStrb_t;

endpackage

// File: rtl/redux_slot.sv
module redux_slot #(
  parameter int WORD_W = 42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] heldWord
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWord <= '0;
    end else if (load) begin
      heldWord <= inWord;
    end
  end

endmodule

// File: rtl/redux_alu.sv
module redux_alu
  import redux_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 10
) (
  input  redOp_e            op,
  input  logic [DATA_W-1:0] lData,
  input  logic [TAG_W-1:0]  lTag,
  input  logic [DATA_W-1:0] rData,
  input  logic [TAG_W-1:0]  rTag,
  output logic [DATA_W-1:0] resData,
  output logic [TAG_W-1:0]  resTag
);

  logic rLess, rMore, rWins;

  assign rLess = $signed(rData) < $signed(lData);
  assign rMore = $signed(rData) > $signed(lData);

  always_comb begin
    rWins = 1'b0;
    case (op)
      OP_MIN:  rWins = rLess;
      OP_MAX:  rWins = rMore;
      default: rWins = 1'b0;
    endcase
  end

  always_comb begin
    if (op == OP_ADD) begin
      resData = lData + rData;
      resTag  = lTag;
    end else if (rWins) begin
      resData = rData;
      resTag  = rTag;
    end else begin
      resData = lData;
      resTag  = lTag;
    end
  end

endmodule

// File: rtl/redux_ctrl.sv
module redux_ctrl
  import redux_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       leftValid,
  input  logic       rightValid,
  input  logic       outReady,
  output logic       leftReady,
  output logic       rightReady,
  output logic       outValid,
  output logic       leftFull,
  output logic       rightFull,
  output redOp_e     pairMode,
  output redStrb_t   strb
);

  logic   idle, outFree, pairOk, fire, loadL, loadR, passNow;
  redOp_e effMode;

  assign idle    = !leftFull && !rightFull;
  assign effMode = idle ? redOp_e'(modeIn) : pairMode;
  assign passNow = (effMode == OP_PASS);

  assign outFree = !outValid || outReady;
  assign pairOk  = leftFull && (rightFull || pairMode == OP_PASS);
  assign fire    = pairOk && outFree;

  assign leftReady  = !leftFull || fire;
  assign rightReady = !passNow && (!rightFull || fire);

  assign loadL = leftValid && leftReady;
  assign loadR = rightValid && rightReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftFull  <= 1'b0;
      rightFull <= 1'b0;
      outValid  <= 1'b0;
      pairMode  <= OP_ADD;
    end else begin
      if (idle) begin
        pairMode <= redOp_e'(modeIn);
      end
      leftFull  <= loadL || (leftFull && !fire);
      rightFull <= loadR || (rightFull && !fire);
      outValid  <= fire || (outValid && !outReady);
    end
  end

  always_comb begin
    strb              = '0;
    strb.load[SIDE_L] = loadL;
    strb.load[SIDE_R] = loadR;
    strb.fire         = fire;
    strb.op           = pairMode;
  end

endmodule

// File: rtl/redux_dpath.sv
module redux_dpath
  import redux_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  redStrb_t          strb,
  input  logic [DATA_W-1:0] leftData,
  input  logic [TAG_W-1:0]  leftTag,
  input  logic [DATA_W-1:0] rightData,
  input  logic [TAG_W-1:0]  rightTag,
  output logic [DATA_W-1:0] outData,
  output logic [TAG_W-1:0]  outTag
);

  localparam int WORD_W = DATA_W + TAG_W;

  logic [SIDES-1:0][WORD_W-1:0] inWord;
  logic [SIDES-1:0][WORD_W-1:0] heldWord;
  logic [DATA_W-1:0]            resData;
  logic [TAG_W-1:0]             resTag;

  assign inWord[SIDE_L] = {leftTag, leftData};
  assign inWord[SIDE_R] = {rightTag, rightData};

  for (genvar g = 0; g < SIDES; g++) begin : gSlot
    redux_slot #(.WORD_W(WORD_W)) slot_i (
      .clk     (clk),
      .rstN    (rstN),
      .load    (strb.load[g]),
      .inWord  (inWord[g]),
      .heldWord(heldWord[g])
    );
  end

  redux_alu #(.DATA_W(DATA_W), .TAG_W(TAG_W)) alu_i (
    .op     (strb.op),
    .lData  (heldWord[SIDE_L][DATA_W-1:0]),
    .lTag   (heldWord[SIDE_L][WORD_W-1:DATA_W]),
    .rData  (heldWord[SIDE_R][DATA_W-1:0]),
    .rTag   (heldWord[SIDE_R][WORD_W-1:DATA_W]),
    .resData(resData),
    .resTag (resTag)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outTag  <= '0;
    end else if (strb.fire) begin
      outData <= resData;
      outTag  <= resTag;
    end
  end

endmodule

// File: rtl/redux_node.sv
module redux_node
  import redux_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeIn,
  input  logic              leftValid,
  output logic              leftReady,
  input  logic [DATA_W-1:0] leftData,
  input  logic [TAG_W-1:0]  leftTag,
  input  logic              rightValid,
  output logic              rightReady,
  input  logic [DATA_W-1:0] rightData,
  input  logic [TAG_W-1:0]  rightTag,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [TAG_W-1:0]  outTag
);

  redStrb_t strb;
  logic     leftFull, rightFull;
  redOp_e   pairMode;

  redux_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeIn    (modeIn),
    .leftValid (leftValid),
    .rightValid(rightValid),
    .outReady  (outReady),
    .leftReady (leftReady),
    .rightReady(rightReady),
    .outValid  (outValid),
    .leftFull  (leftFull),
    .rightFull (rightFull),
    .pairMode  (pairMode),
    .strb      (strb)
  );

  redux_dpath #(.DATA_W(DATA_W), .TAG_W(TAG_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .leftData (leftData),
    .leftTag  (leftTag),
    .rightData(rightData),
    .rightTag (rightTag),
    .outData  (outData),
    .outTag   (outTag)
  );

endmodule

// File: rtl/redux_node_chk.sv
module redux_node_chk #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [TAG_W-1:0]  outTag,
  input logic              leftReady,
  input logic              leftFull,
  input logic              rightFull,
  input logic [1:0]        pairMode
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (!outValid && !leftFull && !rightFull)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outTag))); // R7

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (leftFull && outValid && !outReady) |-> !leftReady); // R7

  AST_PAIR_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(leftFull)); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (leftFull || rightFull) |=> (pairMode == $past(pairMode))); // R8

  AST_PASS_NO_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (pairMode == 2'd3 && leftFull) |-> !rightFull); // R4

endmodule

bind redux_node redux_node_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outTag   (outTag),
  .leftReady(leftReady),
  .leftFull (leftFull),
  .rightFull(rightFull),
  .pairMode (pairMode)
);

// File: tb/redux_node_tb_top.sv
`timescale 1ns/1ps
module redux_node_tb_top;

  localparam int DW = 32;
  localparam int TW = 10;
  localparam int LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeIn = 2'd0;
  logic          leftValid = 1'b0, rightValid = 1'b0;
  logic          leftReady, rightReady;
  logic [DW-1:0] leftData = '0, rightData = '0;
  logic [TW-1:0] leftTag = '0, rightTag = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [DW-1:0] outData;
  logic [TW-1:0] outTag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tc = 0;
  logic throttle = 1'b0;
  logic wantReady = 1'b1;
  logic finished = 1'b0;
  string curReq = "R9";
  logic [DW+TW-1:0] expQ[$];

  always #5 clk = ~clk;

  redux_node #(.DATA_W(DW), .TAG_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .modeIn(modeIn),
    .leftValid(leftValid), .leftReady(leftReady), .leftData(leftData), .leftTag(leftTag),
    .rightValid(rightValid), .rightReady(rightReady), .rightData(rightData), .rightTag(rightTag),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outTag(outTag)
  );

  function automatic logic [DW+TW-1:0] calcExp(input int op,
      input logic [DW-1:0] l, input logic [TW-1:0] lt,
      input logic [DW-1:0] r, input logic [TW-1:0] rt);
    int ls, rs;
    logic [DW-1:0] sum;
    ls = $signed(l);
    rs = $signed(r);
    sum = l + r;
    case (op)
      0:       return {lt, sum};
      1:       return (rs < ls) ? {rt, r} : {lt, l};
      2:       return (rs > ls) ? {rt, r} : {lt, l};
      default: return {lt, l};
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // parent ready, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    tc++;
    outReady = throttle ? (tc % 3 != 2) : wantReady;
  end

  // in-order result scoreboard
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected result actual=%h expected=none", {outTag, outData});
      end else begin
        logic [DW+TW-1:0] e;
        e = expQ.pop_front();
        if ({outTag, outData} !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", curReq, {outTag, outData}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic driveLeft(input logic [DW-1:0] d, input logic [TW-1:0] t, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    leftValid = 1'b1; leftData = d; leftTag = t;
    while (!leftReady) @(negedge clk);
    @(negedge clk);
    leftValid = 1'b0;
  endtask

  task automatic driveRight(input logic [DW-1:0] d, input logic [TW-1:0] t, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    rightValid = 1'b1; rightData = d; rightTag = t;
    while (!rightReady) @(negedge clk);
    @(negedge clk);
    rightValid = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  logic [DW-1:0] vals[8];
  logic [DW-1:0] held;

  initial begin
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h8000_0000, 32'd100, 32'hFFFF_FF9C, 32'd7};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    chk("R9", {63'd0, outValid}, 64'd0);
    chk("R9", {63'd0, leftReady}, 64'd1);
    chk("R9", {63'd0, rightReady}, 64'd1);

    // R6 latency with both operands presented together
    curReq = "R6";
    @(negedge clk);
    expQ.push_back(calcExp(0, 32'd5, 10'd3, 32'd7, 10'd4));
    leftValid = 1'b1; leftData = 32'd5; leftTag = 10'd3;
    rightValid = 1'b1; rightData = 32'd7; rightTag = 10'd4;
    @(negedge clk);
    leftValid = 1'b0; rightValid = 1'b0;
    chk("R6", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    chk("R6", {63'd0, outValid}, 64'd1);
    chk("R1", {32'd0, outData}, 64'd12);
    waitDrain();

    // R1 / R2 / R3 sweeps over boundary values, with skewed arrival (R5)
    for (int m = 0; m < 3; m++) begin
      waitDrain();
      modeIn = 2'(m);
      throttle = (m == 2);
      curReq = (m == 0) ? "R1" : ((m == 1) ? "R2" : "R3");
      repeat (2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [TW-1:0] lt, rt;
          lt = TW'(i * 8 + j);
          rt = TW'(64 + i * 8 + j);
          expQ.push_back(calcExp(m, vals[i], lt, vals[j], rt));
          fork
            driveLeft(vals[i], lt, (i + j) % 3);
            driveRight(vals[j], rt, j % 2);
          join
        end
      end
    end
    waitDrain();
    throttle = 1'b0;
    wantReady = 1'b1;

    // R7 back-pressure
    modeIn = 2'd0;
    curReq = "R7";
    @(posedge clk); wantReady = 1'b0;
    @(posedge clk);
    expQ.push_back(calcExp(0, 32'd40, 10'd1, 32'd2, 10'd2));
    fork driveLeft(32'd40, 10'd1, 0); driveRight(32'd2, 10'd2, 0); join
    expQ.push_back(calcExp(0, 32'd9, 10'd5, 32'd1, 10'd6));
    fork driveLeft(32'd9, 10'd5, 0); driveRight(32'd1, 10'd6, 0); join
    @(negedge clk);
    chk("R7", {63'd0, outValid}, 64'd1);
    chk("R7", {32'd0, outData}, 64'd42);
    chk("R7", {63'd0, leftReady}, 64'd0);
    chk("R7", {63'd0, rightReady}, 64'd0);
    held = outData;
    repeat (3) @(negedge clk);
    chk("R7", {32'd0, outData}, {32'd0, held});
    wantReady = 1'b1;
    waitDrain();

    // R8 mode change while a word waits
    curReq = "R8";
    modeIn = 2'd1;
    repeat (2) @(negedge clk);
    driveLeft(32'd9, 10'd11, 0);
    modeIn = 2'd0;
    repeat (2) @(negedge clk);
    chk("R5", {63'd0, outValid}, 64'd0);
    chk("R5", {63'd0, leftReady}, 64'd0);
    expQ.push_back(calcExp(1, 32'd9, 10'd11, 32'd3, 10'd12));
    driveRight(32'd3, 10'd12, 0);
    waitDrain();
    expQ.push_back(calcExp(0, 32'd9, 10'd11, 32'd3, 10'd12));
    fork driveLeft(32'd9, 10'd11, 0); driveRight(32'd3, 10'd12, 1); join
    waitDrain();

    // R4 pass mode, right side offered junk
    curReq = "R4";
    modeIn = 2'd3;
    repeat (2) @(negedge clk);
    rightValid = 1'b1; rightData = 32'hDEAD_BEEF; rightTag = 10'h3FF;
    @(negedge clk);
    chk("R4", {63'd0, rightReady}, 64'd0);
    for (int k = 0; k < 4; k++) begin
      expQ.push_back(calcExp(3, 32'(1000 + k), TW'(20 + k), 32'd0, 10'd0));
      driveLeft(32'(1000 + k), TW'(20 + k), 0);
    end
    chk("R4", {63'd0, rightReady}, 64'd0);
    rightValid = 1'b0;
    waitDrain();
    modeIn = 2'd0;
    repeat (2) @(negedge clk);
    expQ.push_back(calcExp(0, 32'd100, 10'd30, 32'd23, 10'd31));
    fork driveLeft(32'd100, 10'd30, 0); driveRight(32'd23, 10'd31, 0); join
    waitDrain();

    // R5 every queued pair has emerged
    chk("R5", {32'd0, 32'(expQ.size())}, 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule